// File: doc/BRIEF.md
# Display Sequencer Register File

This block is the register file of a legacy display adapter's sequencer. A host reaches it over a byte-wide I/O bus through two ports: an index port that picks a register and a data port that reads or writes it. Only the low `IDX_BITS` bits of a written index are kept, so indices that differ only in their upper bits alias onto the same register. This matches older adapters, where for example index 0x12 reaches the plane write mask.

Five registers are held locally: sequencer reset, clocking mode, plane write mask, font map select and memory mode. From these registers the block drives the following control outputs:
- a sequencer reset request;
- screen blank and attribute-disable levels;
- plane enables, together with a 32-bit byte-expanded mask and its complement;
- two font bank base addresses;
- a chained-addressing flag.

Some writes also raise one-cycle event pulses: a reset event, a resize request and a memory-handler remap. Any index outside the five local registers passes straight through to an extension port.

Top module: `seq_regfile`

## Requirements
- R1: A write to the index port stores `wdata & ((1<<IDX_BITS)-1)`. A read of the index port returns that stored value. With `IDX_BITS`=4, writing 0x12 selects register 2 and writing 0x14 selects register 4.
- R2: While `rst_n` is low, every register clears. After reset, `seq_rst_req`=1, `blank`=0, `plane_en`=0, `plane_mask32`=0, `plane_nmask32`=0xFFFFFFFF, both font bases are 0, `chained`=0 and all pulses are 0.
- R3: Register 0 stores all 8 bits. `seq_rst_req` is 1 unless bits 1:0 of register 0 are both 1. `seq_rst_evt` is high for the one cycle after a register 0 write whose bits 1:0 differ from the stored bits 1:0.
- R4: `blank` and `attr_dis` both equal bit 5 (screen off) of register 1. Register 1 stores all 8 bits.
- R5: `resize_pulse` is high for the one cycle after a register 1 write that changes any bit other than bit 5. A write that changes only bit 5, or changes nothing, gives no pulse.
- R6: Register 2 keeps only bits 3:0 and reads back with bits 7:4 as 0. `plane_en` equals those four bits. Byte i of `plane_mask32` is all ones when plane bit i is set and all zeros otherwise. `plane_nmask32` is the bitwise complement of `plane_mask32`.
- R7: Register 3 stores all 8 bits. Font select A is {bit1, bit0, bit4}, with bit4 as the least significant bit. Font select B is {bit3, bit2, bit5}, with bit5 as the least significant bit. Each font base equals its select times 8192.
- R8: `chained` equals bit 3 of register 4. `remap_pulse` is high for the one cycle after every write to register 4, whatever value is written.
- R9: A data-port read of index 0 to 4 returns the stored register. At any other index, a read asserts `ext_rd` and returns `ext_rdata` when `ext_hit` is 1 and 0 otherwise. A write at such an index asserts `ext_wr` in the same cycle and leaves all local registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_idx | input | 1 | Access targets the index port |
| sel_dat | input | 1 | Access targets the data port |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Read enable, data returned combinationally |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| ext_wr | output | 1 | Write forwarded to the extension port |
| ext_rd | output | 1 | Read forwarded to the extension port |
| ext_idx | output | 8 | Stored index, shown to the extension port |
| ext_wdata | output | 8 | Write data to the extension port |
| ext_rdata | input | 8 | Read data from the extension port |
| ext_hit | input | 1 | Extension claims the current read |
| seq_rst_req | output | 1 | Sequencer reset request level |
| seq_rst_evt | output | 1 | Pulse: reset bits 1:0 changed |
| blank | output | 1 | Screen blanked |
| attr_dis | output | 1 | Attribute controller disable |
| resize_pulse | output | 1 | Pulse: timing-relevant clocking change |
| plane_en | output | 4 | Plane write enables |
| plane_mask32 | output | 32 | Byte-expanded plane mask |
| plane_nmask32 | output | 32 | Complement of the expanded mask |
| font_a_base | output | 16 | Font bank base address A |
| font_b_base | output | 16 | Font bank base address B |
| chained | output | 1 | Chained addressing selected |
| remap_pulse | output | 1 | Pulse: memory mode written |

## Verification
Two functions can change in the same cycle: the screen-off change, which moves `blank`, and the resize request. The bench provokes this with one clocking-mode write that flips bit 5 together with other bits. It expects `blank` to move and `resize_pulse` to rise in the same cycle. As a contrast, it checks that a write flipping bit 5 alone moves `blank` and gives no pulse. It also checks that rewriting an unchanged value gives neither.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int DW            = 8;
  localparam int PLANES        = 4;
  localparam int FONT_SEL_W    = 3;
  localparam int BANK_SHIFT    = 13;
  localparam int FONT_ADDR_W   = FONT_SEL_W + BANK_SHIFT;

  localparam logic [DW-1:0] IX_RESET   = 8'h00;
  localparam logic [DW-1:0] IX_CLOCK   = 8'h01;
  localparam logic [DW-1:0] IX_PLANE   = 8'h02;
  localparam logic [DW-1:0] IX_FONT    = 8'h03;
  localparam logic [DW-1:0] IX_MEMMODE = 8'h04;

  localparam int SCREEN_OFF_BIT = 5;
  localparam int CHAIN_BIT      = 3;

  function automatic logic is_local(input logic [DW-1:0] ix);
    return ix <= IX_MEMMODE;
  endfunction
endpackage

// File: rtl/seq_index_reg.sv
module seq_index_reg
  import seq_pkg::*;
#(
  parameter int IDX_BITS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] q
);
  localparam logic [DW-1:0] IDX_MASK = DW'((1 << IDX_BITS) - 1);

  logic [DW-1:0] d;

  always_comb begin
    d = din & IDX_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q <= d;
    end
  end
endmodule

// File: rtl/seq_core_regs.sv
module seq_core_regs
  import seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DW-1:0]     idx,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     reset_q,
  output logic [DW-1:0]     clock_q,
  output logic [PLANES-1:0] plane_q,
  output logic [DW-1:0]     font_q,
  output logic [DW-1:0]     mem_q,
  output logic              rst_evt_q,
  output logic              resize_q,
  output logic              remap_q
);
  localparam logic [DW-1:0] KEEP_MASK = ~(DW'(1) << SCREEN_OFF_BIT);

  logic en_reset, en_clock, en_plane, en_font, en_mem;
  logic rst_evt_d, resize_d, remap_d;

  always_comb begin
    en_reset  = wr_en && (idx == IX_RESET);
    en_clock  = wr_en && (idx == IX_CLOCK);
    en_plane  = wr_en && (idx == IX_PLANE);
    en_font   = wr_en && (idx == IX_FONT);
    en_mem    = wr_en && (idx == IX_MEMMODE);
    rst_evt_d = en_reset && ((reset_q[1:0] ^ wdata[1:0]) != 2'b00);
    resize_d  = en_clock && (((clock_q ^ wdata) & KEEP_MASK) != '0);
    remap_d   = en_mem;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reset_q   <= '0;
      clock_q   <= '0;
      plane_q   <= '0;
      font_q    <= '0;
      mem_q     <= '0;
      rst_evt_q <= 1'b0;
      resize_q  <= 1'b0;
      remap_q   <= 1'b0;
    end else begin
      if (en_reset) reset_q <= wdata;
      if (en_clock) clock_q <= wdata;
      if (en_plane) plane_q <= wdata[PLANES-1:0];
      if (en_font)  font_q  <= wdata;
      if (en_mem)   mem_q   <= wdata;
      rst_evt_q <= rst_evt_d;
      resize_q  <= resize_d;
      remap_q   <= remap_d;
    end
  end
endmodule

// File: rtl/seq_font_map.sv
module seq_font_map
  import seq_pkg::*;
(
  input  logic [1:0]             hi_bits,
  input  logic                   lo_bit,
  output logic [FONT_ADDR_W-1:0] base
);
  logic [FONT_SEL_W-1:0] sel;

  always_comb begin
    sel  = {hi_bits, lo_bit};
    base = {sel, {BANK_SHIFT{1'b0}}};
  end
endmodule

// File: rtl/seq_regfile.sv
module seq_regfile
  import seq_pkg::*;
#(
  parameter int IDX_BITS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sel_idx,
  input  logic                   sel_dat,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          rdata,
  output logic                   ext_wr,
  output logic                   ext_rd,
  output logic [DW-1:0]          ext_idx,
  output logic [DW-1:0]          ext_wdata,
  input  logic [DW-1:0]          ext_rdata,
  input  logic                   ext_hit,
  output logic                   seq_rst_req,
  output logic                   seq_rst_evt,
  output logic                   blank,
  output logic                   attr_dis,
  output logic                   resize_pulse,
  output logic [PLANES-1:0]      plane_en,
  output logic [4*DW-1:0]        plane_mask32,
  output logic [4*DW-1:0]        plane_nmask32,
  output logic [FONT_ADDR_W-1:0] font_a_base,
  output logic [FONT_ADDR_W-1:0] font_b_base,
  output logic                   chained,
  output logic                   remap_pulse
);
  logic [DW-1:0]     idx_q;
  logic [DW-1:0]     reset_q, clock_q, font_q, mem_q;
  logic [PLANES-1:0] plane_q;
  logic              idx_wr, dat_wr, dat_rd, local_hit;

  always_comb begin
    idx_wr    = wr_en && sel_idx;
    dat_wr    = wr_en && sel_dat && !sel_idx;
    dat_rd    = rd_en && sel_dat && !sel_idx;
    local_hit = is_local(idx_q);
  end

  seq_index_reg #(.IDX_BITS(IDX_BITS)) u_index (
    .clk  (clk),
    .rst_n(rst_n),
    .load (idx_wr),
    .din  (wdata),
    .q    (idx_q)
  );

  seq_core_regs u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (dat_wr),
    .idx      (idx_q),
    .wdata    (wdata),
    .reset_q  (reset_q),
    .clock_q  (clock_q),
    .plane_q  (plane_q),
    .font_q   (font_q),
    .mem_q    (mem_q),
    .rst_evt_q(seq_rst_evt),
    .resize_q (resize_pulse),
    .remap_q  (remap_pulse)
  );

  // Two font selects, each with a two-bit high field and one scattered LSB
  logic [1:0] fhi [2];
  logic       flo [2];
  logic [FONT_ADDR_W-1:0] fbase [2];

  always_comb begin
    fhi[0] = font_q[1:0];
    flo[0] = font_q[4];
    fhi[1] = font_q[3:2];
    flo[1] = font_q[5];
  end

  for (genvar g = 0; g < 2; g++) begin : g_font
    seq_font_map u_map (
      .hi_bits(fhi[g]),
      .lo_bit (flo[g]),
      .base   (fbase[g])
    );
  end

  assign font_a_base = fbase[0];
  assign font_b_base = fbase[1];

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    assign plane_mask32[p*DW +: DW] = {DW{plane_q[p]}};
  end
  assign plane_nmask32 = ~plane_mask32;
  assign plane_en      = plane_q;

  assign seq_rst_req = (reset_q[1:0] != 2'b11);
  assign blank       = clock_q[SCREEN_OFF_BIT];
  assign attr_dis    = clock_q[SCREEN_OFF_BIT];
  assign chained     = mem_q[CHAIN_BIT];

  assign ext_idx   = idx_q;
  assign ext_wdata = wdata;
  assign ext_wr    = dat_wr && !local_hit;
  assign ext_rd    = dat_rd && !local_hit;

  always_comb begin
    rdata = '0;
    if (rd_en && sel_idx) begin
      rdata = idx_q;
    end else if (dat_rd) begin
      case (idx_q)
        IX_RESET:   rdata = reset_q;
        IX_CLOCK:   rdata = clock_q;
        IX_PLANE:   rdata = {{(DW-PLANES){1'b0}}, plane_q};
        IX_FONT:    rdata = font_q;
        IX_MEMMODE: rdata = mem_q;
        default:    rdata = ext_hit ? ext_rdata : '0;
      endcase
    end
  end
endmodule

// File: rtl/seq_regfile_chk.sv
module seq_regfile_chk
  import seq_pkg::*;
#(
  parameter int IDX_BITS = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel_idx,
  input logic          sel_dat,
  input logic          wr_en,
  input logic [DW-1:0] ext_idx,
  input logic          ext_wr,
  input logic          seq_rst_evt,
  input logic          blank,
  input logic          resize_pulse,
  input logic          remap_pulse
);
  localparam logic [DW-1:0] HI_MASK = ~DW'((1 << IDX_BITS) - 1);

  logic dwr;
  assign dwr = wr_en && sel_dat && !sel_idx;

  a_r1_idx_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_idx & HI_MASK) == '0);

  a_r3_evt_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    seq_rst_evt |-> $past(dwr && ext_idx == IX_RESET));

  a_r4_blank_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(dwr && ext_idx == IX_CLOCK) |=> $stable(blank));

  a_r5_resize_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    resize_pulse |-> $past(dwr && ext_idx == IX_CLOCK));

  a_r8_remap_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && ext_idx == IX_MEMMODE) |=> remap_pulse);

  a_r9_ext_only_outside: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr |-> (dwr && ext_idx > IX_MEMMODE));
endmodule

bind seq_regfile seq_regfile_chk #(.IDX_BITS(IDX_BITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sel_idx     (sel_idx),
  .sel_dat     (sel_dat),
  .wr_en       (wr_en),
  .ext_idx     (ext_idx),
  .ext_wr      (ext_wr),
  .seq_rst_evt (seq_rst_evt),
  .blank       (blank),
  .resize_pulse(resize_pulse),
  .remap_pulse (remap_pulse)
);

// File: tb/sim_seq_regfile.sv
module sim_seq_regfile;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel_idx, sel_dat, wr_en, rd_en;
  logic [7:0]  wdata, rdata, ext_idx, ext_wdata, ext_rdata;
  logic        ext_wr, ext_rd, ext_hit;
  logic        seq_rst_req, seq_rst_evt, blank, attr_dis, resize_pulse;
  logic [3:0]  plane_en;
  logic [31:0] plane_mask32, plane_nmask32;
  logic [15:0] font_a_base, font_b_base;
  logic        chained, remap_pulse;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_regfile #(.IDX_BITS(4)) u0 (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    sel_idx = 0; sel_dat = 0; wr_en = 0; rd_en = 0; wdata = '0;
  endtask

  task automatic wr_idx(input logic [7:0] v);
    @(negedge clk);
    sel_idx = 1; wr_en = 1; wdata = v;
    @(negedge clk);
    idle();
  endtask

  task automatic wr_dat(input logic [7:0] v);
    @(negedge clk);
    sel_dat = 1; wr_en = 1; wdata = v;
    @(negedge clk);
    idle();
  endtask

  task automatic rd_port(input logic use_idx, output logic [7:0] v);
    sel_idx = use_idx; sel_dat = !use_idx; rd_en = 1;
    #1 v = rdata;
    idle();
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rst_n = 0; idle(); ext_hit = 0; ext_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R2 seq_rst_req", seq_rst_req, 1);
    check("R2 blank", blank, 0);
    check("R2 plane_mask32", plane_mask32, 0);
    check("R2 plane_nmask32", plane_nmask32, 32'hFFFFFFFF);
    check("R2 fonts", {font_a_base, font_b_base}, 0);
    check("R2 chained/pulses", {chained, seq_rst_evt, resize_pulse, remap_pulse}, 0);
    rd_port(0, v);
    check("R2 reg0 read", v, 0);
  endtask

  task automatic t_alias();
    logic [7:0] v;
    wr_idx(8'h12);
    rd_port(1, v);
    check("R1 index 0x12 masked", v, 8'h02);
    wr_dat(8'hA5);
    check("R6 plane_en via alias", plane_en, 4'h5);
    rd_port(0, v);
    check("R6 reg2 upper bits dropped", v, 8'h05);
    check("R6 plane_mask32", plane_mask32, 32'h00FF00FF);
    check("R6 plane_nmask32", plane_nmask32, 32'hFF00FF00);
    wr_idx(8'hF3);
    rd_port(1, v);
    check("R1 index 0xF3 masked", v, 8'h03);
  endtask

  task automatic t_reset_reg();
    logic [7:0] v;
    wr_idx(8'h00);
    wr_dat(8'h03);
    check("R3 evt on 00->11", seq_rst_evt, 1);
    check("R3 req released", seq_rst_req, 0);
    wr_dat(8'h83);
    check("R3 no evt when bits 1:0 kept", seq_rst_evt, 0);
    rd_port(0, v);
    check("R3 reg0 read", v, 8'h83);
    wr_dat(8'h01);
    check("R3 evt on 11->01", seq_rst_evt, 1);
    check("R3 req asserted", seq_rst_req, 1);
  endtask

  task automatic t_clock();
    logic [7:0] v;
    wr_idx(8'h01);
    wr_dat(8'h20);
    check("R4 blank on", {blank, attr_dis}, 2'b11);
    check("R5 no resize for bit5 only", resize_pulse, 0);
    wr_dat(8'h21);
    check("R5 resize on bit0", resize_pulse, 1);
    check("R4 blank held", blank, 1);
    wr_dat(8'h01);
    check("R4 blank off", {blank, attr_dis}, 2'b00);
    check("R5 no resize bit5 off", resize_pulse, 0);
    wr_dat(8'h28);
    check("R5 same-cycle resize", resize_pulse, 1);
    check("R4 same-cycle blank", blank, 1);
    wr_dat(8'h28);
    check("R5 no resize unchanged", resize_pulse, 0);
    rd_port(0, v);
    check("R4 reg1 read", v, 8'h28);
  endtask

  task automatic t_font();
    wr_idx(8'h03);
    wr_dat(8'h13);
    check("R7 A=7 B=0", {font_a_base, font_b_base}, {16'hE000, 16'h0000});
    wr_dat(8'h2C);
    check("R7 A=0 B=7", {font_a_base, font_b_base}, {16'h0000, 16'hE000});
    wr_dat(8'h09);
    check("R7 A=2 B=4", {font_a_base, font_b_base}, {16'h4000, 16'h8000});
  endtask

  task automatic t_memmode();
    logic [7:0] v;
    wr_idx(8'h14);
    wr_dat(8'h08);
    check("R8 chained set", chained, 1);
    check("R8 remap pulse", remap_pulse, 1);
    @(negedge clk);
    check("R8 remap one cycle", remap_pulse, 0);
    wr_dat(8'h08);
    check("R8 remap on same value", remap_pulse, 1);
    wr_dat(8'h00);
    check("R8 chained clear", chained, 0);
    rd_port(0, v);
    check("R8 reg4 read", v, 8'h00);
  endtask

  task automatic t_ext();
    logic [7:0] v;
    wr_idx(8'h07);
    @(negedge clk);
    sel_dat = 1; wr_en = 1; wdata = 8'h3C;
    #1;
    check("R9 ext_wr", ext_wr, 1);
    check("R9 ext idx/data", {ext_idx, ext_wdata}, {8'h07, 8'h3C});
    @(negedge clk);
    idle();
    check("R9 plane_en untouched", plane_en, 4'h5);
    check("R9 chained untouched", chained, 0);
    ext_hit = 1; ext_rdata = 8'h5A;
    sel_dat = 1; rd_en = 1;
    #1;
    check("R9 ext_rd", ext_rd, 1);
    check("R9 ext read hit", rdata, 8'h5A);
    idle();
    ext_hit = 0;
    rd_port(0, v);
    check("R9 ext read miss", v, 8'h00);
    wr_idx(8'h02);
    rd_port(0, v);
    check("R9 reg2 after ext write", v, 8'h05);
  endtask

  initial begin
    t_reset();
    t_alias();
    t_reset_reg();
    t_clock();
    t_font();
    t_memmode();
    t_ext();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule